// File: doc/BRIEF.md
# Low-Power Mode Control Registers

This block is a pair of power-management registers on an APB slave port. The command word at offset 0x00 holds two fields. The first chooses what a CPU deep-sleep request turns into: standby, or stop. The second chooses the regulator state used during stop. The same word carries two write-one command bits that clear the standby and wakeup event flags. The status word at offset 0x04 holds the backup-regulator enable and the wakeup-pin enable. It also reports the backup-regulator ready indication, the voltage-detector output and the two event flags.

The block turns the deep-sleep request and the two selection bits into a 2-bit low-power mode code, which the clock and regulator control outside the block consumes. Three reset inputs keep the storage apart. A power reset clears the status word but leaves the backup-regulator enable alone. A system reset, which is also how a standby wakeup shows up here, clears only the command word and the bus logic. The backup-domain reset is the only reset that clears the backup-regulator enable. A status read takes extra wait states, which are set by a parameter.

Top module: `lpModeRegs`

## Requirements
- R1: Only word offsets 0x00 (command) and 0x04 (status) are mapped. A read of any other offset returns 0 with no wait state, and a write there changes nothing. PSLVERR is always low.
- R2: A read of offset 0x04 holds PREADY low for the first STAT_WAIT access cycles (default 2). Every other access completes in its first access cycle.
- R3: Command bits 1 (standby select) and 0 (low-power regulator in stop) are read/write. Command bits 3 and 2 always read 0, and bits 31:4 read 0 and ignore writes.
- R4: lpMode is 0 while deepSleepReq is low. While deepSleepReq is high, lpMode is 3 if command bit 1 is 1, 2 if command bit 1 is 0 and bit 0 is 1, and 1 if both bits are 0.
- R5: Writing 1 to command bit 3 clears the standby flag at the clock edge that completes the write. Writing 0 there leaves the flag unchanged.
- R6: Writing 1 to command bit 2 clears the wakeup flag CLR_DLY clock edges (default 2) after the edge that completes the write. The flag still reads 1 in the cycle in between.
- R7: A one-cycle pulse on sbyEvt or wkupEvt sets the standby flag (status bit 1) or the wakeup flag (status bit 0). If a set pulse and a clear land on the same edge, the flag ends up set.
- R8: Status bit 9 is the backup-regulator enable and bit 8 is the wakeup-pin enable; both are read/write and drive bregEnOut and wkupPinEn. Bits 3:0 are read-only: 3 is regulator ready, 2 is pvdIn, 1 is the standby flag and 0 is the wakeup flag. All other bits read 0.
- R9: porRstn clears both flags, the wakeup-pin enable and the command word. sysRstn clears only the command word. Only bkpRstn clears the backup-regulator enable.
- R10: Status bit 3 is bregRdyIn while the backup-regulator enable is set, and 0 whenever the enable is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and system clock |
| porRstn | input | 1 | Power reset, active low, asynchronous |
| sysRstn | input | 1 | System or standby-wakeup reset, active low |
| bkpRstn | input | 1 | Backup-domain reset, active low |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready |
| pslverr | output | 1 | APB error, always low |
| sbyEvt | input | 1 | One-cycle event that sets the standby flag |
| wkupEvt | input | 1 | One-cycle event that sets the wakeup flag |
| bregRdyIn | input | 1 | Backup regulator ready indication |
| pvdIn | input | 1 | Voltage detector output |
| deepSleepReq | input | 1 | CPU deep-sleep request |
| lpMode | output | 2 | Decoded low-power mode code |
| bregEnOut | output | 1 | Backup regulator enable |
| wkupPinEn | output | 1 | Wakeup pin enable |

## Verification
The hazard is an event pulse that arrives on the same edge where a flag clear takes effect. For the standby flag, that edge is the one that completes the command write. For the wakeup flag, it comes CLR_DLY edges after the write. The bench raises sbyEvt during the access cycle of a clearing write. For the wakeup flag, it forks a status read with a pulse that it places in the cycle before the delayed clear. The flag must still read 1 in both cases. The bench confirms that a plain clear without a pulse still works.

// File: rtl/lpModePkg.sv
package lpModePkg;

  typedef enum logic [1:0] {
    MODE_RUN     = 2'd0,
    MODE_STOP_ON = 2'd1,
    MODE_STOP_LP = 2'd2,
    MODE_STANDBY = 2'd3
  } lpMode_e;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CMD  = 2'd1,
    SEL_STAT = 2'd2
  } regSel_e;

  typedef struct packed {
    logic    wrCmd;
    logic    wrStat;
    regSel_e rdSel;
  } busStrobe_t;

  // command word bit positions
  localparam int CMD_LPREG = 0;
  localparam int CMD_SBYSEL = 1;
  localparam int CMD_CLRWK = 2;
  localparam int CMD_CLRSB = 3;

  // status word bit positions
  localparam int ST_WKF = 0;
  localparam int ST_SBF = 1;
  localparam int ST_PVD = 2;
  localparam int ST_RDY = 3;
  localparam int ST_WPEN = 8;
  localparam int ST_BREN = 9;

endpackage

// File: rtl/lpBusCtrl.sv
module lpBusCtrl
  import lpModePkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int STAT_WAIT = 2
) (
  input  logic              pclk,
  input  logic              rstn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  output logic              pready,
  output logic              pslverr,
  output busStrobe_t        strobe
);

  localparam int CNT_W = (STAT_WAIT > 0) ? $clog2(STAT_WAIT + 1) : 1;
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [CNT_W-1:0] WAIT_LAST = CNT_W'(STAT_WAIT);

  logic [CNT_W-1:0] waitCnt;
  logic [IDX_W-1:0] wordIdx;
  logic isCmd, isStat, access, needWait, done;

  assign wordIdx = paddr[ADDR_W-1:2];
  assign isCmd   = (wordIdx == IDX_W'(0));
  assign isStat  = (wordIdx == IDX_W'(1));
  assign access  = psel & penable;

  // status reads stall until the counter reaches the wait count
  assign needWait = access & ~pwrite & isStat & (waitCnt != WAIT_LAST);
  assign pready   = ~needWait;
  assign pslverr  = 1'b0;
  assign done     = access & pready;

  always_ff @(posedge pclk or negedge rstn) begin
    if (!rstn)         waitCnt <= '0;
    else if (needWait) waitCnt <= waitCnt + CNT_W'(1);
    else               waitCnt <= '0;
  end

  always_comb begin
    strobe.wrCmd  = done & pwrite & isCmd;
    strobe.wrStat = done & pwrite & isStat;
    strobe.rdSel  = SEL_NONE;
    if (access && !pwrite) begin
      if (isCmd)       strobe.rdSel = SEL_CMD;
      else if (isStat) strobe.rdSel = SEL_STAT;
    end
  end

endmodule

// File: rtl/lpRegFile.sv
module lpRegFile
  import lpModePkg::*;
#(
  parameter int CLR_DLY = 2
) (
  input  logic        pclk,
  input  logic        sysRstn,
  input  logic        porRstn,
  input  logic        bkpRstn,
  input  busStrobe_t  strobe,
  input  logic [31:0] pwdata,
  input  logic        sbyEvt,
  input  logic        wkupEvt,
  input  logic        bregRdyIn,
  input  logic        pvdIn,
  input  logic        deepSleepReq,
  output logic [31:0] prdata,
  output logic [1:0]  lpMode,
  output logic        bregEn,
  output logic        wkupPinEn,
  output logic        sbyFlag,
  output logic        wkupFlag
);

  logic sbySel, lpReg, bregRdy;
  logic sbyClr, wkClrReq, wkClr;
  logic [CLR_DLY-1:0] clrPipe;
  logic [31:0] cmdWord, statWord;
  lpMode_e modeNext;

  assign sbyClr   = strobe.wrCmd & pwdata[CMD_CLRSB];
  assign wkClrReq = strobe.wrCmd & pwdata[CMD_CLRWK];

  // command word: system reset domain
  always_ff @(posedge pclk or negedge sysRstn) begin
    if (!sysRstn) begin
      sbySel <= 1'b0;
      lpReg  <= 1'b0;
    end else if (strobe.wrCmd) begin
      sbySel <= pwdata[CMD_SBYSEL];
      lpReg  <= pwdata[CMD_LPREG];
    end
  end

  // delayed wakeup-flag clear
  generate
    if (CLR_DLY == 1) begin : gSingle
      always_ff @(posedge pclk or negedge sysRstn) begin
        if (!sysRstn) clrPipe <= '0;
        else          clrPipe <= wkClrReq;
      end
    end else begin : gShift
      always_ff @(posedge pclk or negedge sysRstn) begin
        if (!sysRstn) clrPipe <= '0;
        else          clrPipe <= {clrPipe[CLR_DLY-2:0], wkClrReq};
      end
    end
  endgenerate
  assign wkClr = clrPipe[CLR_DLY-1];

  // flags and pin enable: power reset domain, set wins over clear
  always_ff @(posedge pclk or negedge porRstn) begin
    if (!porRstn) begin
      sbyFlag   <= 1'b0;
      wkupFlag  <= 1'b0;
      wkupPinEn <= 1'b0;
    end else begin
      if (sbyEvt)      sbyFlag <= 1'b1;
      else if (sbyClr) sbyFlag <= 1'b0;
      if (wkupEvt)     wkupFlag <= 1'b1;
      else if (wkClr)  wkupFlag <= 1'b0;
      if (strobe.wrStat) wkupPinEn <= pwdata[ST_WPEN];
    end
  end

  // backup regulator enable: backup domain only
  always_ff @(posedge pclk or negedge bkpRstn) begin
    if (!bkpRstn)           bregEn <= 1'b0;
    else if (strobe.wrStat) bregEn <= pwdata[ST_BREN];
  end

  assign bregRdy = bregEn & bregRdyIn;

  always_comb begin
    cmdWord = '0;
    cmdWord[CMD_SBYSEL] = sbySel;
    cmdWord[CMD_LPREG]  = lpReg;
    statWord = '0;
    statWord[ST_BREN] = bregEn;
    statWord[ST_WPEN] = wkupPinEn;
    statWord[ST_RDY]  = bregRdy;
    statWord[ST_PVD]  = pvdIn;
    statWord[ST_SBF]  = sbyFlag;
    statWord[ST_WKF]  = wkupFlag;
  end

  always_comb begin
    unique case (strobe.rdSel)
      SEL_CMD:  prdata = cmdWord;
      SEL_STAT: prdata = statWord;
      default:  prdata = '0;
    endcase
  end

  always_comb begin
    if (!deepSleepReq) modeNext = MODE_RUN;
    else if (sbySel)   modeNext = MODE_STANDBY;
    else if (lpReg)    modeNext = MODE_STOP_LP;
    else               modeNext = MODE_STOP_ON;
  end
  assign lpMode = modeNext;

endmodule

// File: rtl/lpModeRegs.sv
module lpModeRegs
  import lpModePkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int STAT_WAIT = 2,
  parameter int CLR_DLY   = 2
) (
  input  logic              pclk,
  input  logic              porRstn,
  input  logic              sysRstn,
  input  logic              bkpRstn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic              sbyEvt,
  input  logic              wkupEvt,
  input  logic              bregRdyIn,
  input  logic              pvdIn,
  input  logic              deepSleepReq,
  output logic [1:0]        lpMode,
  output logic              bregEnOut,
  output logic              wkupPinEn
);

  busStrobe_t strobe;
  logic sysRstnEff;
  logic sbyFlag, wkupFlag;

  // a power reset also resets the system domain
  assign sysRstnEff = sysRstn & porRstn;

  lpBusCtrl #(.ADDR_W(ADDR_W), .STAT_WAIT(STAT_WAIT)) u_ctrl (
    .pclk(pclk), .rstn(sysRstnEff), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pready(pready), .pslverr(pslverr),
    .strobe(strobe)
  );

  lpRegFile #(.CLR_DLY(CLR_DLY)) u_regs (
    .pclk(pclk), .sysRstn(sysRstnEff), .porRstn(porRstn), .bkpRstn(bkpRstn),
    .strobe(strobe), .pwdata(pwdata), .sbyEvt(sbyEvt), .wkupEvt(wkupEvt),
    .bregRdyIn(bregRdyIn), .pvdIn(pvdIn), .deepSleepReq(deepSleepReq),
    .prdata(prdata), .lpMode(lpMode), .bregEn(bregEnOut),
    .wkupPinEn(wkupPinEn), .sbyFlag(sbyFlag), .wkupFlag(wkupFlag)
  );

endmodule

// File: rtl/lpModeRegsChk.sv
module lpModeRegsChk #(
  parameter int ADDR_W    = 8,
  parameter int STAT_WAIT = 2
) (
  input logic              pclk,
  input logic              porRstn,
  input logic              sysRstn,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [31:0]       pwdata,
  input logic [31:0]       prdata,
  input logic              pready,
  input logic              sbyEvt,
  input logic              wkupEvt,
  input logic              deepSleepReq,
  input logic [1:0]        lpMode,
  input logic              bregEnOut,
  input logic              sbyFlag,
  input logic              wkupFlag
);

  logic acc, cmdSel, statSel, mapped, cmdDone;
  assign acc     = psel & penable;
  assign cmdSel  = (paddr[ADDR_W-1:2] == '0);
  assign statSel = (paddr[ADDR_W-1:2] == (ADDR_W-2)'(1));
  assign mapped  = cmdSel | statSel;
  assign cmdDone = acc & pready & pwrite & cmdSel;

  AST_UNMAPPED_ZERO: assert property (@(posedge pclk) disable iff (!porRstn || !sysRstn)
    (acc && !mapped) |-> (pready && prdata == 32'd0)); // R1

  AST_STAT_WAIT: assert property (@(posedge pclk) disable iff (!porRstn || !sysRstn)
    ((STAT_WAIT > 0) && acc && !pwrite && statSel && !$past(acc)) |-> !pready); // R2

  AST_CMD_READ_ZERO: assert property (@(posedge pclk) disable iff (!porRstn || !sysRstn)
    (acc && !pwrite && cmdSel) |-> (prdata[31:2] == 30'd0)); // R3

  AST_MODE_IDLE: assert property (@(posedge pclk) disable iff (!porRstn || !sysRstn)
    !deepSleepReq |-> (lpMode == 2'd0)); // R4

  AST_SBY_CLEAR: assert property (@(posedge pclk) disable iff (!porRstn || !sysRstn)
    $past(cmdDone && pwdata[3] && !sbyEvt) |-> !sbyFlag); // R5

  AST_WK_HOLD: assert property (@(posedge pclk) disable iff (!porRstn || !sysRstn)
    $past(cmdDone && pwdata[2] && wkupFlag) |-> wkupFlag); // R6

  AST_SBY_SET_WINS: assert property (@(posedge pclk) disable iff (!porRstn || !sysRstn)
    $past(sbyEvt) |-> sbyFlag); // R7

  AST_WK_SET_WINS: assert property (@(posedge pclk) disable iff (!porRstn || !sysRstn)
    $past(wkupEvt) |-> wkupFlag); // R7

  AST_STAT_RSVD: assert property (@(posedge pclk) disable iff (!porRstn || !sysRstn)
    (acc && !pwrite && statSel) |-> (prdata[31:10] == 22'd0 && prdata[7:4] == 4'd0)); // R8

  AST_RDY_OFF: assert property (@(posedge pclk) disable iff (!porRstn || !sysRstn)
    (acc && !pwrite && statSel && !bregEnOut) |-> !prdata[3]); // R10

endmodule

bind lpModeRegs lpModeRegsChk #(.ADDR_W(ADDR_W), .STAT_WAIT(STAT_WAIT)) u_chk (
  .pclk(pclk), .porRstn(porRstn), .sysRstn(sysRstn), .psel(psel),
  .penable(penable), .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
  .prdata(prdata), .pready(pready), .sbyEvt(sbyEvt), .wkupEvt(wkupEvt),
  .deepSleepReq(deepSleepReq), .lpMode(lpMode), .bregEnOut(bregEnOut),
  .sbyFlag(sbyFlag), .wkupFlag(wkupFlag)
);

// File: tb/lpModeRegs_bench.sv
module lpModeRegs_bench;

  logic pclk = 1'b0;
  logic porRstn, sysRstn, bkpRstn;
  logic psel, penable, pwrite;
  logic [7:0] paddr;
  logic [31:0] pwdata, prdata;
  logic pready, pslverr;
  logic sbyEvt, wkupEvt, bregRdyIn, pvdIn, deepSleepReq;
  logic [1:0] lpMode;
  logic bregEnOut, wkupPinEn;

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 pclk = ~pclk;

  lpModeRegs u_lpModeRegs (
    .pclk(pclk), .porRstn(porRstn), .sysRstn(sysRstn), .bkpRstn(bkpRstn),
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
    .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
    .sbyEvt(sbyEvt), .wkupEvt(wkupEvt), .bregRdyIn(bregRdyIn), .pvdIn(pvdIn),
    .deepSleepReq(deepSleepReq), .lpMode(lpMode), .bregEnOut(bregEnOut),
    .wkupPinEn(wkupPinEn)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  task automatic apbWrite(input logic [7:0] addr, input logic [31:0] data,
                          input bit pulseSby = 1'b0);
    @(negedge pclk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = addr; pwdata = data;
    @(negedge pclk);
    penable = 1'b1;
    if (pulseSby) sbyEvt = 1'b1;
    #1;
    while (!pready) begin @(negedge pclk); #1; end
    @(posedge pclk); #1;
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0; sbyEvt = 1'b0;
  endtask

  task automatic apbRead(input logic [7:0] addr, output logic [31:0] first,
                         output logic [31:0] data, output int waits,
                         output logic err);
    @(negedge pclk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = addr;
    @(negedge pclk);
    penable = 1'b1;
    #1;
    first = prdata;
    waits = 0;
    while (!pready) begin @(negedge pclk); #1; waits++; end
    data = prdata;
    err = pslverr;
    @(posedge pclk); #1;
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic pulseEvt(input bit wk);
    @(negedge pclk);
    if (wk) wkupEvt = 1'b1; else sbyEvt = 1'b1;
    @(negedge pclk);
    wkupEvt = 1'b0; sbyEvt = 1'b0;
  endtask

  task automatic testReset();
    logic [31:0] f, d; int w; logic e;
    apbRead(8'h00, f, d, w, e); chk("R9 reset command word", d, 32'h0);
    apbRead(8'h04, f, d, w, e); chk("R9 reset status word", d, 32'h0);
    chk("R4 reset mode", {30'd0, lpMode}, 32'd0);
  endtask

  task automatic testMapWait();
    logic [31:0] f, d; int w; logic e;
    apbRead(8'h00, f, d, w, e);
    chk("R2 command read waits", w, 0);
    apbRead(8'h04, f, d, w, e);
    chk("R2 status read waits", w, 2);
    apbWrite(8'h00, 32'h3);
    apbWrite(8'h08, 32'hFFFF_FFFF);
    apbRead(8'h08, f, d, w, e);
    chk("R1 unmapped read data", d, 32'h0);
    chk("R1 unmapped read waits", w, 0);
    chk("R1 pslverr low", {31'd0, e}, 32'd0);
    apbRead(8'h00, f, d, w, e);
    chk("R1 unmapped write leaves command", d, 32'h3);
    apbRead(8'h04, f, d, w, e);
    chk("R1 unmapped write leaves status", d, 32'h0);
  endtask

  task automatic testCmdBits();
    logic [31:0] f, d; int w; logic e;
    apbWrite(8'h00, 32'hF);
    apbRead(8'h00, f, d, w, e);
    chk("R3 command bits readback", d, 32'h3);
    apbWrite(8'h00, 32'hFFFF_FFF0);
    apbRead(8'h00, f, d, w, e);
    chk("R3 upper bits ignored", d, 32'h0);
  endtask

  task automatic testMode();
    for (int v = 0; v < 4; v++) begin
      logic [1:0] exp;
      apbWrite(8'h00, 32'(v));
      exp = (v[1]) ? 2'd3 : (v[0] ? 2'd2 : 2'd1);
      @(negedge pclk); deepSleepReq = 1'b0; #1;
      chk("R4 mode without request", {30'd0, lpMode}, 32'd0);
      @(negedge pclk); deepSleepReq = 1'b1; #1;
      chk("R4 mode with request", {30'd0, lpMode}, {30'd0, exp});
      @(negedge pclk); deepSleepReq = 1'b0;
    end
  endtask

  task automatic testSbyClear();
    logic [31:0] f, d; int w; logic e;
    pulseEvt(1'b0);
    apbRead(8'h04, f, d, w, e); chk("R7 standby flag set", {31'd0, d[1]}, 32'd1);
    apbWrite(8'h00, 32'h0);
    apbRead(8'h04, f, d, w, e); chk("R5 zero write keeps flag", {31'd0, d[1]}, 32'd1);
    apbWrite(8'h00, 32'h8);
    apbRead(8'h04, f, d, w, e); chk("R5 standby clear immediate", {31'd0, f[1]}, 32'd0);
  endtask

  task automatic testWkupClear();
    logic [31:0] f, d; int w; logic e;
    pulseEvt(1'b1);
    apbRead(8'h04, f, d, w, e); chk("R7 wakeup flag set", {31'd0, d[0]}, 32'd1);
    apbWrite(8'h00, 32'h4);
    apbRead(8'h04, f, d, w, e);
    chk("R6 wakeup flag still set before delay", {31'd0, f[0]}, 32'd1);
    chk("R6 wakeup flag cleared after delay", {31'd0, d[0]}, 32'd0);
  endtask

  task automatic testCollision();
    logic [31:0] f, d; int w; logic e;
    pulseEvt(1'b0);
    apbWrite(8'h00, 32'h8, 1'b1);
    apbRead(8'h04, f, d, w, e);
    chk("R7 standby set beats clear", {31'd0, d[1]}, 32'd1);
    pulseEvt(1'b1);
    apbWrite(8'h00, 32'h4);
    fork
      apbRead(8'h04, f, d, w, e);
      begin
        @(negedge pclk); @(negedge pclk);
        wkupEvt = 1'b1;
        @(negedge pclk);
        wkupEvt = 1'b0;
      end
    join
    chk("R7 wakeup set beats delayed clear", {31'd0, d[0]}, 32'd1);
    apbWrite(8'h00, 32'hC);
    apbRead(8'h04, f, d, w, e);
    chk("R5 R6 both flags cleared", {30'd0, d[1:0]}, 32'd0);
  endtask

  task automatic testStatusBits();
    logic [31:0] f, d; int w; logic e;
    bregRdyIn = 1'b1; pvdIn = 1'b1;
    apbRead(8'h04, f, d, w, e);
    chk("R10 ready hidden while disabled", {31'd0, d[3]}, 32'd0);
    apbWrite(8'h04, 32'h30F);
    apbRead(8'h04, f, d, w, e);
    chk("R8 status layout", d, 32'h30C);
    chk("R8 enable outputs", {30'd0, bregEnOut, wkupPinEn}, 32'h3);
    apbWrite(8'h04, 32'h100);
    apbRead(8'h04, f, d, w, e);
    chk("R10 ready low after disable", d, 32'h104);
    chk("R10 enable output low", {31'd0, bregEnOut}, 32'd0);
    apbWrite(8'h04, 32'h300);
  endtask

  task automatic testResets();
    logic [31:0] f, d; int w; logic e;
    apbWrite(8'h00, 32'h3);
    pulseEvt(1'b0); pulseEvt(1'b1);
    @(negedge pclk); sysRstn = 1'b0;
    @(negedge pclk); sysRstn = 1'b1;
    apbRead(8'h00, f, d, w, e); chk("R9 system reset clears command", d, 32'h0);
    apbRead(8'h04, f, d, w, e); chk("R9 system reset keeps status", d, 32'h30F);
    @(negedge pclk); porRstn = 1'b0;
    @(negedge pclk); porRstn = 1'b1;
    apbRead(8'h04, f, d, w, e); chk("R9 power reset keeps backup enable", d, 32'h20C);
    @(negedge pclk); bkpRstn = 1'b0;
    @(negedge pclk); bkpRstn = 1'b1;
    apbRead(8'h04, f, d, w, e); chk("R9 backup reset clears enable", d, 32'h4);
    chk("R9 backup enable output", {31'd0, bregEnOut}, 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge pclk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=hung expected=complete");
      summary();
    end
  end

  initial begin
    porRstn = 1'b0; sysRstn = 1'b0; bkpRstn = 1'b0;
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0; paddr = '0; pwdata = '0;
    sbyEvt = 1'b0; wkupEvt = 1'b0; bregRdyIn = 1'b0; pvdIn = 1'b0;
    deepSleepReq = 1'b0;
    repeat (3) @(negedge pclk);
    porRstn = 1'b1; sysRstn = 1'b1; bkpRstn = 1'b1;
    testReset();
    testMapWait();
    testCmdBits();
    testMode();
    testSbyClear();
    testWkupClear();
    testCollision();
    testStatusBits();
    testResets();
    done = 1'b1;
    summary();
  end

endmodule